// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Core

This block is a 32-bit in-order processor core that overlaps five instructions at once. The five stages are fetch, decode with register read, ALU execute, data memory access and result write-back. Four pipeline registers sit between the stages and load on every clock edge. The core has no stall, flush or forwarding logic, so every instruction advances one stage per cycle. A combinational decoder in the decode stage produces the control bits. Those bits travel with the instruction, grouped by the stage that consumes them. The core runs four kinds of instruction: load word, store word, register-register arithmetic/logic, and branch-if-equal.

Instruction memory and data memory are small internal word arrays. A preload port fills them while reset is held. A combinational peek port reads data memory back for checking. The register-file write port is brought out to the pins so that each retired result can be observed.

Software must place independent instructions or no-ops between dependent ones. A consumer must sit at least three slots after its producer. The three slots after a branch always execute.

Top module: `pipe5_core`

## Requirements
- R1: An instruction with opcode 0x00 (bits 31:26) is register-register. Its function field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The result goes to register rd (bits 15:11), with the sources rs (bits 25:21) and rt (bits 20:16). The word 0x00000000 is therefore a no-op.
- R2: Opcode 0x23 loads and opcode 0x2B stores. Both form the byte address as rs plus the sign-extended 16-bit immediate, and both use address bits above bit 1 as the word index. A load writes into rt. A store writes rt's value into data memory.
- R3: Results reach the write-back port in program order. Each result carries the destination number that its own instruction selected: rt for loads, rd for register-register instructions.
- R4: Register 0 reads as zero and never appears on the write-back port. A value written back is visible to a decode-stage read in the same cycle, so a consumer three slots after its producer receives the new value.
- R5: Opcode 0x04 is branch-if-equal. Its target is PC+4 plus the sign-extended immediate times four. The decision is made in the memory stage, so the three instructions after the branch still complete. Instructions skipped by a taken branch never write back.
- R6: The PC steps by 4 every cycle unless a branch is taken. An instruction fetched in cycle n shows its result on the write-back port after the fourth rising edge following that fetch.
- R7: A synchronous active-high reset sets the PC to 0 and clears every control bit in the pipeline. While reset is held, the write-back port stays idle and no store changes data memory.
- R8: The preload port writes instruction memory (select 0) or data memory (select 1) at a word index. The peek port returns the data-memory word at its index combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | clog2(MEM_WORDS) | Preload word index |
| ld_data | input | 32 | Preload word |
| peek_addr | input | clog2(MEM_WORDS) | Data-memory read-back word index |
| peek_data | output | 32 | Data-memory word at peek_addr |
| pc_out | output | 32 | Current fetch address |
| wb_en | output | 1 | Register-file write strobe (never set for register 0) |
| wb_reg | output | 5 | Register number being written |
| wb_data | output | 32 | Value being written |

## Verification
The assertions assume that the preload port is used only while reset is held, so program stores and preload writes never collide on data memory. They also assume that PC redirection comes only from branches resolved in the memory stage. Because there is no hazard logic, results are correct only for hazard-free programs. The stimulus program therefore keeps every producer at least three slots ahead of its consumer, puts one pair at exactly three slots to exercise the same-cycle write/read path, and fills each branch's three shadow slots with instructions whose effects are expected.

// File: rtl/p5_pkg.sv
package p5_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  // ALU mode selected by the decoder: add for addresses, subtract for compare, function field otherwise
  localparam logic [1:0] AM_ADD = 2'b00;
  localparam logic [1:0] AM_SUB = 2'b01;
  localparam logic [1:0] AM_FN  = 2'b10;

  typedef struct packed {
    logic       imm_src;   // second operand is the immediate
    logic       dst_rd;    // destination is rd instead of rt
    logic [1:0] alu_mode;
  } ex_ctl_t;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
    logic is_branch;
  } mem_ctl_t;

  typedef struct packed {
    logic from_mem;
    logic reg_wr;
  } wb_ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_plus4,
                                                  input logic [15:0] off);
    logic [XLEN-1:0] s;
    s = sext16(off);
    return pc_plus4 + (s << 2);
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/p5_ctrl.sv
module p5_ctrl
  import p5_pkg::*;
(
  input  logic [5:0] opcode,
  output ex_ctl_t    ex_ctl,
  output mem_ctl_t   mem_ctl,
  output wb_ctl_t    wb_ctl
);

  always_comb begin
    ex_ctl  = '0;
    mem_ctl = '0;
    wb_ctl  = '0;
    case (opcode)
      OPC_REG: begin
        ex_ctl.dst_rd   = 1'b1;
        ex_ctl.alu_mode = AM_FN;
        wb_ctl.reg_wr   = 1'b1;
      end
      OPC_LOAD: begin
        ex_ctl.imm_src  = 1'b1;
        ex_ctl.alu_mode = AM_ADD;
        mem_ctl.rd_en   = 1'b1;
        wb_ctl.from_mem = 1'b1;
        wb_ctl.reg_wr   = 1'b1;
      end
      OPC_STORE: begin
        ex_ctl.imm_src  = 1'b1;
        ex_ctl.alu_mode = AM_ADD;
        mem_ctl.wr_en   = 1'b1;
      end
      OPC_BEQ: begin
        ex_ctl.alu_mode   = AM_SUB;
        mem_ctl.is_branch = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/p5_alu.sv
module p5_alu
  import p5_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [5:0]      funct,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            is_zero
);

  alu_op_e op;

  always_comb begin
    case (mode)
      AM_SUB: op = ALU_SUB;
      AM_FN: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end

  assign result  = alu_eval(op, opa, opb);
  assign is_zero = (result == '0);

endmodule

// File: rtl/p5_regfile.sv
module p5_regfile
  import p5_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [REG_AW-1:0] raddr_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // write-then-read within one cycle: a matching write is returned directly
  function automatic logic [XLEN-1:0] read_port(input logic [REG_AW-1:0] ra);
    if (ra == '0)                return '0;
    else if (we && waddr == ra)  return wdata;
    else                         return regs[ra];
  endfunction

  assign rdata_a = read_port(raddr_a);
  assign rdata_b = read_port(raddr_b);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import p5_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int MAW = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_sel,
  input  logic [MAW-1:0]    ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  input  logic [MAW-1:0]    peek_addr,
  output logic [XLEN-1:0]   peek_data,
  output logic [XLEN-1:0]   pc_out,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_reg,
  output logic [XLEN-1:0]   wb_data
);

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } fd_t;

  typedef struct packed {
    ex_ctl_t           ex;
    mem_ctl_t          mem;
    wb_ctl_t           wb;
    logic [XLEN-1:0]   pc4;
    logic [XLEN-1:0]   va;
    logic [XLEN-1:0]   vb;
    logic [15:0]       imm;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
  } de_t;

  typedef struct packed {
    mem_ctl_t          mem;
    wb_ctl_t           wb;
    logic [XLEN-1:0]   target;
    logic              zero;
    logic [XLEN-1:0]   alu;
    logic [XLEN-1:0]   sdata;
    logic [REG_AW-1:0] dst;
  } em_t;

  typedef struct packed {
    wb_ctl_t           wb;
    logic [XLEN-1:0]   mdata;
    logic [XLEN-1:0]   alu;
    logic [REG_AW-1:0] dst;
  } mw_t;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q;
  fd_t fd_q;
  de_t de_q;
  em_t em_q;
  mw_t mw_q;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_plus4, pc_next, fetch_word;
  logic            br_take;
  logic [XLEN-1:0] br_target;

  assign pc_plus4   = pc_q + 32'd4;
  assign fetch_word = imem[pc_q[MAW+1:2]];
  assign pc_next    = br_take ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      fd_q <= '0;
    end else begin
      pc_q <= pc_next;
      fd_q <= '{pc4: pc_plus4, instr: fetch_word};
    end
  end

  // ---------------- decode ----------------
  logic [5:0]        d_op;
  logic [REG_AW-1:0] rs_sel, rt_sel, rd_sel;
  logic [15:0]       d_imm;
  logic [XLEN-1:0]   rs_data, rt_data;
  ex_ctl_t           d_ex;
  mem_ctl_t          d_mem;
  wb_ctl_t           d_wb;

  assign d_op   = fd_q.instr[31:26];
  assign rs_sel = fd_q.instr[25:21];
  assign rt_sel = fd_q.instr[20:16];
  assign rd_sel = fd_q.instr[15:11];
  assign d_imm  = fd_q.instr[15:0];

  p5_ctrl u_ctrl (
    .opcode  (d_op),
    .ex_ctl  (d_ex),
    .mem_ctl (d_mem),
    .wb_ctl  (d_wb)
  );

  p5_regfile #(.NREGS(32)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .waddr   (wb_reg),
    .wdata   (wb_data),
    .raddr_a (rs_sel),
    .raddr_b (rt_sel),
    .rdata_a (rs_data),
    .rdata_b (rt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q.ex  <= '0;
      de_q.mem <= '0;
      de_q.wb  <= '0;
    end else begin
      de_q <= '{ex: d_ex, mem: d_mem, wb: d_wb, pc4: fd_q.pc4, va: rs_data,
                vb: rt_data, imm: d_imm, rt: rt_sel, rd: rd_sel};
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0]   x_opb, x_res;
  logic              x_zero;
  logic [REG_AW-1:0] x_dst;

  assign x_opb = de_q.ex.imm_src ? sext16(de_q.imm) : de_q.vb;
  assign x_dst = de_q.ex.dst_rd ? de_q.rd : de_q.rt;

  p5_alu u_alu (
    .mode    (de_q.ex.alu_mode),
    .funct   (de_q.imm[5:0]),
    .opa     (de_q.va),
    .opb     (x_opb),
    .result  (x_res),
    .is_zero (x_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      em_q.mem <= '0;
      em_q.wb  <= '0;
    end else begin
      em_q <= '{mem: de_q.mem, wb: de_q.wb, target: branch_dest(de_q.pc4, de_q.imm),
                zero: x_zero, alu: x_res, sdata: de_q.vb, dst: x_dst};
    end
  end

  // ---------------- memory ----------------
  logic [MAW-1:0]    m_idx;
  logic [XLEN-1:0]   m_rdata;
  logic              ex2wb_regwr;
  logic [REG_AW-1:0] ex2wb_dst;

  assign m_idx       = em_q.alu[MAW+1:2];
  assign m_rdata     = dmem[m_idx];
  assign br_take     = em_q.mem.is_branch & em_q.zero;
  assign br_target   = em_q.target;
  assign ex2wb_regwr = em_q.wb.reg_wr;
  assign ex2wb_dst   = em_q.dst;

  always_ff @(posedge clk) begin
    if (ld_we && !ld_sel) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_sel)              dmem[ld_addr] <= ld_data;
    else if (!rst && em_q.mem.wr_en)  dmem[m_idx]   <= em_q.sdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_q.wb <= '0;
    end else begin
      mw_q <= '{wb: em_q.wb, mdata: m_rdata, alu: em_q.alu, dst: em_q.dst};
    end
  end

  // ---------------- write-back ----------------
  assign wb_en   = mw_q.wb.reg_wr && (mw_q.dst != '0);
  assign wb_reg  = mw_q.dst;
  assign wb_data = mw_q.wb.from_mem ? mw_q.mdata : mw_q.alu;

  assign pc_out    = pc_q;
  assign peek_data = dmem[peek_addr];

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], em_q.alu[XLEN-1:MAW+2], em_q.alu[1:0], em_q.mem.rd_en};

endmodule

// File: rtl/p5_checker.sv
module p5_checker
  import p5_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc_q,
  input logic              br_take,
  input logic [XLEN-1:0]   br_target,
  input logic              ex2wb_regwr,
  input logic [REG_AW-1:0] ex2wb_dst,
  input logic              wb_en,
  input logic [REG_AW-1:0] wb_reg,
  input logic [XLEN-1:0]   wb_data,
  input logic [REG_AW-1:0] rs_sel,
  input logic [XLEN-1:0]   rs_data
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pc_q == '0 && !wb_en)); // R7

  AST_PC_STEPS: assert property (@(posedge clk) disable iff (rst)
    !br_take |=> pc_q == $past(pc_q) + 32'd4); // R6

  AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    br_take |=> pc_q == $past(br_target)); // R5

  AST_DST_RIDES_ALONG: assert property (@(posedge clk) disable iff (rst)
    (ex2wb_regwr && ex2wb_dst != '0) |=> (wb_en && wb_reg == $past(ex2wb_dst))); // R3

  AST_SAME_CYCLE_READ: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_reg == rs_sel) |-> rs_data == wb_data); // R4

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs_sel == '0) |-> rs_data == '0); // R4

endmodule

bind pipe5_core p5_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_q        (pc_q),
  .br_take     (br_take),
  .br_target   (br_target),
  .ex2wb_regwr (ex2wb_regwr),
  .ex2wb_dst   (ex2wb_dst),
  .wb_en       (wb_en),
  .wb_reg      (wb_reg),
  .wb_data     (wb_data),
  .rs_sel      (rs_sel),
  .rs_data     (rs_data)
);

// File: tb/tb_pipe5_core.sv
`timescale 1ns/1ps
module tb_pipe5_core;

  localparam int MEM_WORDS = 64;
  localparam int MAW = $clog2(MEM_WORDS);
  localparam int PLEN = 31;
  localparam int NWB = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst = 1'b1;
  logic           ld_we = 1'b0, ld_sel = 1'b0;
  logic [MAW-1:0] ld_addr = '0, peek_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [31:0]    peek_data, pc_out, wb_data;
  logic           wb_en;
  logic [4:0]     wb_reg;

  pipe5_core #(.MEM_WORDS(MEM_WORDS)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .pc_out(pc_out), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  // expected write-back stream: {register, value}
  localparam logic [36:0] EXP_WB [NWB] = '{
    {5'd1,  32'd5},
    {5'd2,  32'd7},
    {5'd3,  32'hFFFF_FFF0},
    {5'd4,  32'd12},          // R1 add
    {5'd5,  32'hFFFF_FFFE},   // R1 sub
    {5'd6,  32'd0},           // R1 and
    {5'd7,  32'hFFFF_FFF5},   // R1 or
    {5'd8,  32'd1},           // R1 slt signed
    {5'd9,  32'd10},          // R5 shadow slot executes
    {5'd11, 32'd14}           // R5 not-taken path
  };

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  logic [31:0] prog [PLEN];

  initial begin
    for (int i = 0; i < PLEN; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);      // r1 <- mem[0]
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);      // r2 <- mem[1]
    prog[2]  = enc_i(6'h23, 0, 3, 16'd8);      // r3 <- mem[2]
    prog[5]  = enc_r(1, 2, 4, 6'h20);
    prog[6]  = enc_r(1, 2, 5, 6'h22);
    prog[7]  = enc_r(2, 3, 6, 6'h24);
    prog[8]  = enc_r(1, 3, 7, 6'h25);
    prog[9]  = enc_r(3, 1, 8, 6'h2A);
    prog[11] = enc_i(6'h2B, 0, 4, 16'd12);
    prog[12] = enc_i(6'h2B, 0, 5, 16'd16);
    prog[13] = enc_i(6'h04, 1, 1, 16'd6);      // taken, to slot 20
    prog[14] = enc_r(1, 1, 9, 6'h20);          // shadow slot
    prog[17] = enc_r(1, 1, 10, 6'h20);         // skipped
    prog[20] = enc_i(6'h2B, 0, 9, 16'd20);
    prog[21] = enc_i(6'h04, 1, 2, 16'd5);      // not taken
    prog[22] = enc_r(2, 2, 11, 6'h20);
    prog[25] = enc_i(6'h2B, 2, 11, 16'd17);    // 3 slots after producer, base r2
    prog[26] = enc_r(1, 1, 0, 6'h20);          // write to r0
    prog[29] = enc_i(6'h2B, 0, 0, 16'd28);     // store r0
    prog[30] = enc_i(6'h04, 0, 0, 16'hFFFF);   // spin in place
  end

  // ---------- write-back monitor ----------
  bit mon_on = 1'b0;
  int cyc = 0, wb_idx = 0, first_wb = -1;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (cyc == 1) check(pc_out == 32'd4, "R6 pc after first edge", pc_out, 32'd4);
      if (cyc == 2) check(pc_out == 32'd8, "R6 pc after second edge", pc_out, 32'd8);
      if (wb_en) begin
        if (first_wb < 0) begin
          first_wb = cyc;
          check(cyc == 4, "R6 first write-back cycle", cyc, 32'd4);
        end
        if (wb_idx < NWB) begin
          check(wb_reg == EXP_WB[wb_idx][36:32], "R3 write-back register",
                {27'd0, wb_reg}, {27'd0, EXP_WB[wb_idx][36:32]});
          check(wb_data == EXP_WB[wb_idx][31:0], "R1 R2 write-back value",
                wb_data, EXP_WB[wb_idx][31:0]);
        end else begin
          check(1'b0, "R5 R4 unexpected write-back", {27'd0, wb_reg}, 32'd0);
        end
        wb_idx++;
      end
    end
  end

  task automatic load_word(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = idx[MAW-1:0]; ld_data = d;
  endtask

  task automatic peek_check(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    peek_addr = idx[MAW-1:0];
    #1;
    check(peek_data == exp, tag, peek_data, exp);
  endtask

  initial begin
    // R8: preload both memories while reset is held
    for (int i = 0; i < MEM_WORDS; i++) load_word(1'b0, i, (i < PLEN) ? prog[i] : 32'h0);
    for (int i = 0; i < MEM_WORDS; i++) load_word(1'b1, i, 32'h0);
    load_word(1'b1, 0, 32'd5);
    load_word(1'b1, 1, 32'd7);
    load_word(1'b1, 2, 32'hFFFF_FFF0);
    load_word(1'b1, 7, 32'hDEAD_BEEF);
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    check(pc_out == 32'd0, "R7 pc held at zero in reset", pc_out, 32'd0);
    check(!wb_en, "R7 write-back idle in reset", {31'd0, wb_en}, 32'd0);
    peek_check(7, 32'hDEAD_BEEF, "R8 preload visible on peek");

    @(negedge clk);
    rst = 1'b0;
    #1 mon_on = 1'b1;
    repeat (150) @(negedge clk);
    #1 mon_on = 1'b0;

    check(wb_idx == NWB, "R3 R5 write-back count", wb_idx, NWB);
    peek_check(3, 32'd12,        "R2 store of add result");
    peek_check(4, 32'hFFFF_FFFE, "R2 store of sub result");
    peek_check(5, 32'd10,        "R5 shadow-slot result stored after branch");
    peek_check(6, 32'd14,        "R4 same-cycle write/read with base+offset");
    peek_check(7, 32'd0,         "R4 register zero reads zero");
    peek_check(0, 32'd5,         "R8 untouched word keeps preload");

    // R7: reset while the spin loop is running
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pc_out == 32'd0, "R7 pc cleared by mid-run reset", pc_out, 32'd0);
    check(!wb_en, "R7 write-back cleared by mid-run reset", {31'd0, wb_en}, 32'd0);
    repeat (3) @(negedge clk);
    check(pc_out == 32'd0, "R7 pc stays zero while reset held", pc_out, 32'd0);
    peek_check(3, 32'd12, "R7 memory unchanged across reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule